// File: doc/BRIEF.md
# Complex Downconvert and Decimate-by-Six Channel

This block pulls one narrow signal out of a real, wideband sample stream and hands it on as complex baseband at one sixth of the input rate. A numerically controlled oscillator, tuned by a programmable frequency word, rotates the chosen carrier down to zero frequency. The real input is multiplied by cosine and by negative sine to form the I and Q rails.

Each rail then runs through three filters. The first is a low-pass filter that keeps one sample in three. It blocks what would otherwise alias in that decimation and also trims out-of-band noise. The second is a half-band filter that keeps one sample in two. The third is a short FIR at the output rate that cleans up the band edge and lifts the droop left by the two decimators. In a wideband receiver one instance serves one navigation system. Software loads the frequency word that places that system's carrier at zero.

Every stage rounds half up and saturates to a 16-bit internal word. The two rails are identical and stay cycle-aligned. A single valid strobe marks each output pair.

Top module: `ddc_chan`

## Requirements
- R1: While reset is asserted and until the first output, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: A pulse on `fword_we` loads `fword_in`. The 32-bit phase advances by the loaded word once per accepted input sample and starts from 0 after reset. With a word of 0 and a constant input x, the outputs settle to I = floor((x*32767 + 1024) / 2048) and Q = 0, because every filter has a DC gain of exactly one.
- R3: The mixer forms I + jQ = x * exp(-j*theta), where theta is the top 10 phase bits read through a quarter-wave sine table of amplitude 32767. For a constant input with word 89478485 (fs/48), the output phase moves by -45 degrees per output sample. I and Q always update on the same strobe.
- R4: Exactly one output is produced per six accepted inputs. The first output follows the sixth input after reset. `out_valid` rises at the third rising edge after the edge that takes that sixth sample, lasts one cycle, and never appears on two consecutive cycles.
- R5: Cycles with `in_valid` low change nothing. Outputs and filter state hold, and a gapped stream gives the same output values as an unbroken one.
- R6: The filter taps are {3,12,30,48,70,48,30,12,3}/256 for the decimate-by-3 stage, {-16,0,80,128,80,0,-16}/256 for the half-band stage (its zero taps get no multiplier), and {-12,-20,320,-20,-12}/256 for the output FIR. A tone at fs/48 comes out with an amplitude of 15999.5 times the product of the three stages' responses, within 2 %.
- R7: A real tone at half the input rate (input alternating +1000 and -1000, word 0) is suppressed to a magnitude of at most 4 LSB after settling.
- R8: Each stage saturates to the range -32768..32767 rather than wrapping. A step from 0 to a constant input of 2047 produces a peak `out_i` of exactly 32767, and the output then settles at 32751.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks an input sample |
| in_sample | input | 12 | Real input sample, two's complement |
| fword_we | input | 1 | Loads the oscillator frequency word |
| fword_in | input | 32 | Frequency word (phase step per input sample) |
| out_valid | output | 1 | Marks an output I/Q pair |
| out_i | output | 16 | In-phase output, two's complement |
| out_q | output | 16 | Quadrature output, two's complement |

## Verification
There are four registers between input and output: the mixer, the decimate-by-3 stage, the half-band stage and the output FIR. An output pair therefore appears three rising edges after the edge that takes the sixth, twelfth, ... input. The latency check counts clock edges from the negative edge at which each input is driven and expects the strobe at exactly that count and at no other. The value checks do not depend on that timing. They collect every pair at the negative edge while `out_valid` is high, and they judge steady-state levels, amplitude and phase rotation only after the first twenty outputs, once all three filters hold only stimulus samples.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int SMP_W = 16;
  localparam int ACC_W = 48;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t SAT_HI = acc_t'((64'sd1 <<< (SMP_W-1)) - 64'sd1);
  localparam acc_t SAT_LO = acc_t'(-(64'sd1 <<< (SMP_W-1)));

  // round half up by sh bits, then clip to the sample width
  function automatic smp_t rnd_sat(input acc_t v, input int unsigned sh);
    acc_t half;
    acc_t t;
    half = (sh > 0) ? (acc_t'(1) <<< (sh - 1)) : '0;
    t = (v + half) >>> sh;
    if (t > SAT_HI)      return smp_t'(SAT_HI);
    else if (t < SAT_LO) return smp_t'(SAT_LO);
    else                 return smp_t'(t);
  endfunction
endpackage

// File: rtl/ddc_mix.sv
module ddc_mix
  import ddc_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int PH_W   = 32,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_sample,
  input  logic            fword_we,
  input  logic [PH_W-1:0] fword_in,
  output logic            mix_v,
  output smp_t            mix_i,
  output smp_t            mix_q
);
  localparam int QBITS  = LUT_AW - 2;
  localparam int QN     = 1 << QBITS;
  localparam int MIX_SH = AMP_W - 1 - (SMP_W - IN_W);

  typedef logic signed [AMP_W-1:0] amp_t;

  function automatic amp_t qsin(input int i);
    real v;
    v = (2.0 ** (AMP_W - 1) - 1.0) * $sin(3.141592653589793 * real'(i) / real'(2 * QN));
    return amp_t'($rtoi(v + 0.5));
  endfunction

  amp_t qtab [QN+1];
  for (genvar g = 0; g <= QN; g++) begin : g_tab
    assign qtab[g] = qsin(g);
  end

  logic [PH_W-1:0]   phase_q, phase_d, fword_q, fword_d;
  logic [LUT_AW-1:0] idx;
  logic [1:0]        quad;
  logic [QBITS:0]    off, off_c;
  amp_t              sin_v, cos_v;
  logic signed [IN_W+AMP_W-1:0] prod_c, prod_s;
  smp_t              mi_d, mq_d;

  assign idx   = phase_q[PH_W-1 -: LUT_AW];
  assign quad  = idx[LUT_AW-1 -: 2];
  assign off   = {1'b0, idx[QBITS-1:0]};
  assign off_c = (QBITS+1)'(QN) - off;

  always_comb begin
    unique case (quad)
      2'd0:    begin sin_v =  qtab[off];   cos_v =  qtab[off_c]; end
      2'd1:    begin sin_v =  qtab[off_c]; cos_v = -qtab[off];   end
      2'd2:    begin sin_v = -qtab[off];   cos_v = -qtab[off_c]; end
      default: begin sin_v = -qtab[off_c]; cos_v =  qtab[off];   end
    endcase
  end

  always_comb begin
    fword_d = fword_we ? fword_in : fword_q;
    phase_d = in_valid ? phase_q + fword_q : phase_q;
    prod_c  = $signed(in_sample) * cos_v;
    prod_s  = $signed(in_sample) * sin_v;
    mi_d    = in_valid ? rnd_sat(acc_t'(prod_c), MIX_SH) : mix_i;
    mq_d    = in_valid ? rnd_sat(-acc_t'(prod_s), MIX_SH) : mix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      fword_q <= '0;
      mix_i   <= '0;
      mix_q   <= '0;
      mix_v   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fword_q <= fword_d;
      mix_i   <= mi_d;
      mix_q   <= mq_d;
      mix_v   <= in_valid;
    end
  end

  // R2: phase moves only on accepted samples
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));
endmodule

// File: rtl/ddc_fir.sv
module ddc_fir
  import ddc_pkg::*;
#(
  parameter int NTAP      = 9,
  parameter int DEC       = 3,
  parameter int SH        = 8,
  parameter bit HALF_BAND = 1'b0,
  parameter int COEF [NTAP] = '{default: 0}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_v,
  input  smp_t din,
  output logic out_v,
  output smp_t dout
);
  localparam int CW  = (DEC > 1) ? $clog2(DEC) : 1;
  localparam int CTR = (NTAP - 1) / 2;

  smp_t          hist [NTAP-1];
  acc_t          prod [NTAP];
  acc_t          acc;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          keep;
  smp_t          dout_d;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (HALF_BAND && k != CTR && (k % 2) == (CTR % 2)) begin : g_zero
      assign prod[k] = '0;
    end else if (k == 0) begin : g_head
      assign prod[k] = acc_t'(din) * acc_t'(COEF[k]);
    end else begin : g_mul
      assign prod[k] = acc_t'(hist[k-1]) * acc_t'(COEF[k]);
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc += prod[k];
    keep   = in_v && (cnt_q == CW'(DEC - 1));
    cnt_d  = in_v ? ((cnt_q == CW'(DEC - 1)) ? '0 : cnt_q + 1'b1) : cnt_q;
    dout_d = keep ? rnd_sat(acc, SH) : dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP-1; k++) hist[k] <= '0;
      cnt_q <= '0;
      dout  <= '0;
      out_v <= 1'b0;
    end else begin
      if (in_v) begin
        hist[0] <= din;
        for (int k = 1; k < NTAP-1; k++) hist[k] <= hist[k-1];
      end
      cnt_q <= cnt_d;
      dout  <= dout_d;
      out_v <= keep;
    end
  end

  // R5: idle input cycles leave the stage output untouched
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_v |=> ($stable(dout) && !out_v));
endmodule

// File: rtl/ddc_chan.sv
module ddc_chan
  import ddc_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int PH_W   = 32,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_sample,
  input  logic            fword_we,
  input  logic [PH_W-1:0] fword_in,
  output logic            out_valid,
  output logic [SMP_W-1:0] out_i,
  output logic [SMP_W-1:0] out_q
);
  localparam int N1 = 9;
  localparam int N2 = 7;
  localparam int N3 = 5;
  localparam int C1 [N1] = '{3, 12, 30, 48, 70, 48, 30, 12, 3};
  localparam int C2 [N2] = '{-16, 0, 80, 128, 80, 0, -16};
  localparam int C3 [N3] = '{-12, -20, 320, -20, -12};

  logic [1:0] rs_q;
  logic       rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  logic mix_v;
  smp_t rail_in [2];
  logic v1 [2], v2 [2], v3 [2];
  smp_t d1 [2], d2 [2], d3 [2];

  ddc_mix #(.IN_W(IN_W), .PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_mix (
    .clk(clk), .rst_n(rs_n), .in_valid(in_valid), .in_sample(in_sample),
    .fword_we(fword_we), .fword_in(fword_in),
    .mix_v(mix_v), .mix_i(rail_in[0]), .mix_q(rail_in[1])
  );

  for (genvar r = 0; r < 2; r++) begin : g_rail
    ddc_fir #(.NTAP(N1), .DEC(3), .SH(8), .HALF_BAND(1'b0), .COEF(C1)) u_dec3 (
      .clk(clk), .rst_n(rs_n), .in_v(mix_v), .din(rail_in[r]),
      .out_v(v1[r]), .dout(d1[r]));
    ddc_fir #(.NTAP(N2), .DEC(2), .SH(8), .HALF_BAND(1'b1), .COEF(C2)) u_hb2 (
      .clk(clk), .rst_n(rs_n), .in_v(v1[r]), .din(d1[r]),
      .out_v(v2[r]), .dout(d2[r]));
    ddc_fir #(.NTAP(N3), .DEC(1), .SH(8), .HALF_BAND(1'b0), .COEF(C3)) u_comp (
      .clk(clk), .rst_n(rs_n), .in_v(v2[r]), .din(d2[r]),
      .out_v(v3[r]), .dout(d3[r]));
  end

  assign out_valid = v3[0];
  assign out_i     = d3[0];
  assign out_q     = d3[1];

  // R3: the two rails deliver on the same cycle
  p_rail_align_r3: assert property (@(posedge clk) disable iff (!rs_n)
    v3[0] == v3[1]);
  // R4: an output follows an accepted input by four sampled cycles
  p_latency_r4: assert property (@(posedge clk) disable iff (!rs_n)
    out_valid |-> $past(in_valid, 4));
  // R4: strobes are single-cycle
  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rs_n)
    out_valid |=> !out_valid);
endmodule

// File: tb/test_ddc_chan.sv
module test_ddc_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic        fword_we = 1'b0;
  logic [31:0] fword_in = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  ddc_chan i_ddc_chan (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .fword_we(fword_we), .fword_in(fword_in),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0, ocnt = 0, maxi = -40000;
  int oi [256], oq [256], ocyc [256];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (out_valid) begin
    if (ocnt < 256) begin
      oi[ocnt]   = int'($signed(out_i));
      oq[ocnt]   = int'($signed(out_q));
      ocyc[ocnt] = cyc;
    end
    if (int'($signed(out_i)) > maxi) maxi = int'($signed(out_i));
    ocnt++;
  end

  task automatic report(input bit ok, input string tag, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; fword_we = 1'b0;
    ocnt = 0; maxi = -40000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_fword(input logic [31:0] f);
    @(negedge clk); fword_we = 1'b1; fword_in = f;
    @(negedge clk); fword_we = 1'b0;
  endtask

  task automatic push(input int x, input bit gap);
    @(negedge clk); in_valid = 1'b1; in_sample = 12'(x);
    if (gap) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int mix_dc(input int x);
    longint p;
    p = (longint'(x) * 32767 + 1024) >>> 11;
    return int'(p);
  endfunction

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    report(out_valid == 1'b0 && out_i == 0 && out_q == 0, "R1",
      $sformatf("reset outputs v=%0b i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report(out_valid == 1'b0 && out_i == 0 && out_q == 0, "R1",
      $sformatf("idle after reset v=%0b i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q));
  endtask

  task automatic t_dc(input int x);
    do_reset();
    for (int n = 0; n < 180; n++) push(x, 1'b0);
    idle(8);
    report(oi[ocnt-1] == mix_dc(x), "R2",
      $sformatf("dc I got %0d expected %0d", oi[ocnt-1], mix_dc(x)));
    report(oq[ocnt-1] == 0, "R2", $sformatf("dc Q got %0d expected 0", oq[ocnt-1]));
    report(ocnt == 30, "R4", $sformatf("output count got %0d expected 30", ocnt));
  endtask

  task automatic t_latency();
    int c0;
    do_reset();
    @(negedge clk); c0 = cyc;
    in_valid = 1'b1; in_sample = 12'd5;
    for (int n = 1; n < 12; n++) begin @(negedge clk); in_sample = 12'd5; end
    idle(10);
    report(ocnt == 2, "R4", $sformatf("strobes got %0d expected 2", ocnt));
    report(ocyc[0] == c0 + 9, "R4", $sformatf("first strobe at %0d expected %0d", ocyc[0] - c0, 9));
    report(ocyc[1] == c0 + 15, "R4", $sformatf("second strobe at %0d expected %0d", ocyc[1] - c0, 15));
  endtask

  task automatic t_gaps();
    do_reset();
    for (int n = 0; n < 180; n++) push(-300, 1'b1);
    idle(8);
    report(ocnt == 30, "R5", $sformatf("gapped count got %0d expected 30", ocnt));
    report(oi[ocnt-1] == mix_dc(-300), "R5",
      $sformatf("gapped I got %0d expected %0d", oi[ocnt-1], mix_dc(-300)));
  endtask

  function automatic real resp1(input real w);
    return (70.0 + 2.0*(48.0*$cos(w) + 30.0*$cos(2.0*w) + 12.0*$cos(3.0*w) + 3.0*$cos(4.0*w))) / 256.0;
  endfunction
  function automatic real resp2(input real w);
    return (128.0 + 2.0*(80.0*$cos(w) - 16.0*$cos(3.0*w))) / 256.0;
  endfunction
  function automatic real resp3(input real w);
    return (320.0 + 2.0*(-20.0*$cos(w) - 12.0*$cos(2.0*w))) / 256.0;
  endfunction

  task automatic t_tone();
    real pi_v, w, exp_amp, amp, d, worst;
    pi_v = 3.141592653589793;
    do_reset();
    set_fword(32'd89478485);
    for (int n = 0; n < 360; n++) push(1000, 1'b0);
    idle(8);
    w = 2.0 * pi_v / 48.0;
    exp_amp = 1000.0 * 32767.0 / 2048.0 * resp1(w) * resp2(3.0*w) * resp3(6.0*w);
    amp = 0.0; worst = 0.0;
    for (int k = 20; k < 60; k++) begin
      amp += $sqrt(real'(oi[k])**2 + real'(oq[k])**2) / 40.0;
      d = ($atan2(real'(oq[k]), real'(oi[k])) - $atan2(real'(oq[k-1]), real'(oi[k-1]))) * 180.0 / pi_v;
      if (d > 180.0) d -= 360.0;
      if (d <= -180.0) d += 360.0;
      if ((d + 45.0 > worst) || (-(d + 45.0) > worst)) worst = (d + 45.0 > 0.0) ? d + 45.0 : -(d + 45.0);
    end
    report(worst < 1.5, "R3", $sformatf("phase step error %0f deg expected below 1.5", worst));
    report(amp > 0.98*exp_amp && amp < 1.02*exp_amp, "R6",
      $sformatf("tone amplitude got %0f expected %0f", amp, exp_amp));
  endtask

  task automatic t_stop();
    int worst;
    do_reset();
    for (int n = 0; n < 300; n++) push((n % 2 == 0) ? 1000 : -1000, 1'b0);
    idle(8);
    worst = 0;
    for (int k = 20; k < 50; k++) begin
      if (oi[k] > worst) worst = oi[k];
      if (-oi[k] > worst) worst = -oi[k];
      if (oq[k] > worst) worst = oq[k];
      if (-oq[k] > worst) worst = -oq[k];
    end
    report(worst <= 4, "R7", $sformatf("stop-band residue got %0d expected <= 4", worst));
  endtask

  task automatic t_sat();
    do_reset();
    for (int n = 0; n < 180; n++) push(2047, 1'b0);
    idle(8);
    report(maxi == 32767, "R8", $sformatf("peak I got %0d expected 32767", maxi));
    report(oi[ocnt-1] == 32751, "R8", $sformatf("settled I got %0d expected 32751", oi[ocnt-1]));
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_dc(100);
    t_dc(-300);
    t_latency();
    t_gaps();
    t_tone();
    t_stop();
    t_sat();
    summary();
  end
endmodule